// File: doc/BRIEF.md
# Multi-channel ultrasonic echo timer

This block sits on an 8-bit daisy-chained register bus and drives up to seven ultrasonic rangefinders. All sensors share one trigger output. At a programmable interval, counted in 10 ms strobes, the block raises the trigger for ten 1 µs strobes. It then counts 1 µs strobes on each echo input for as long as that echo stays high. When the next interval ends, the block copies every channel's count into its result registers at once and raises a data-ready flag. It then fires the next trigger.

The host never waits on the block. The bus controller polls each peripheral in turn. When results are pending, the poll reply is the number of bytes to fetch, and the controller then reads the result registers from address 0 upward. Reading the last result byte acknowledges the data. When the block is not selected, it passes the bus data through unchanged, so it can sit anywhere in the chain.

Top module: `sonar_ring_timer`

## Requirements
- R1: After reset the trigger is low, a poll returns 0x00, and every register (addresses 0 to 15) reads 0x00.
- R2: With `bus_sel` low, `bus_dout` equals `bus_din`, `bus_ack` is low, and a write is ignored. With `bus_sel` and `bus_regacc` both high, `bus_ack` is high. `bus_stall` is always low.
- R3: Only `bus_addr[3:0]` is decoded. A write to address 14 latches `bus_din[3:0]` as the interval, and a read of address 14 returns the interval in bits 3:0 with zeros above.
- R4: While the interval is 0, the trigger never rises, whatever strobes arrive.
- R5: After a write of interval N>0, the trigger rises at the clock edge of the Nth 10 ms strobe. It falls at the edge of the 10th 1 µs strobe after rising.
- R6: A new trigger rises at the edge of every Nth 10 ms strobe counted from the previous rise. In each such round, all channels measure together.
- R7: After the trigger falls, a channel counts the 1 µs strobes during which its synchronised echo is high. It stops for good at the first falling edge of the echo, so later pulses in the same round add nothing. The echo passes through a two-flop synchroniser.
- R8: A count saturates at 0xFFFF. A channel whose echo never goes high during the round reports 0.
- R9: Channel n's 16-bit result is at address 2n (high byte) and 2n+1 (low byte).
- R10: Results change only at the end of a round (the interval expires after a trigger). At that same edge the data-ready flag sets. A poll (`bus_sel`=1, `bus_regacc`=0) returns 0x0E while the flag is set and 0x00 otherwise.
- R11: A read of address 13 clears the data-ready flag. Reads of other addresses leave it set.
- R12: Writing the interval during a round abandons that round without updating the results or the flag. Waiting for the first trigger then restarts from zero 10 ms strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | This peripheral is addressed this cycle |
| bus_regacc | input | 1 | 1 for a register access, 0 for a poll |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Register address; bits 3:0 decoded |
| bus_din | input | 8 | Ring data in |
| bus_dout | output | 8 | Ring data out (read data, poll count or pass-through) |
| bus_ack | output | 1 | Register access completed |
| bus_stall | output | 1 | Always low |
| tick_1us | input | 1 | One-cycle strobe every microsecond |
| tick_10ms | input | 1 | One-cycle strobe every 10 ms |
| trig_out | output | 1 | Shared trigger to all sensors |
| echo_in | input | 7 | Echo inputs, bit n is channel n |

## Verification
Register reads and poll replies are combinational, so they are sampled within the same cycle the bench drives them. The trigger, the data-ready flag and the results are registered. They change at the clock edge that takes in the deciding strobe or bus write, and the bench compares them 1 ns after that edge. An echo edge reaches a counter on the third edge after it is driven, so the bench lets three idle cycles pass after each echo change before it sends microsecond strobes. A behavioural model, advanced at every edge with the same inputs, predicts the trigger level for every cycle and the value of every register.

// File: rtl/sonar_pkg.sv
package sonar_pkg;
  // Round state of the measurement controller
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,   // counting toward the first trigger, or idle when interval is 0
    ST_TRIG = 2'd1,   // trigger output high
    ST_MEAS = 2'd2    // echoes being timed
  } sonar_state_e;

  localparam int unsigned ADDR_DEC_W = 4;   // decoded address bits
  localparam int unsigned RESULT_W   = 16;  // bytes-on-bus width of one result
endpackage

// File: rtl/sonar_round_ctl.sv
module sonar_round_ctl
  import sonar_pkg::*;
#(
  parameter int unsigned IVL_W   = 4,
  parameter int unsigned TRIG_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_wr_i,
  input  logic [IVL_W-1:0] ivl_din_i,
  input  logic             tick_us_i,
  input  logic             tick_10ms_i,
  output logic [IVL_W-1:0] ivl_o,
  output logic             trig_o,
  output logic             meas_o,
  output logic             start_o,
  output logic             publish_o
);
  localparam int unsigned TC_W = $clog2(TRIG_US) + 1;

  sonar_state_e     state_q, state_d;
  logic [IVL_W-1:0] ivl_q, ivl_d;
  logic [IVL_W-1:0] c10_q, c10_d;
  logic [TC_W-1:0]  tc_q, tc_d;
  logic             ivl_on;
  logic             expire;

  assign ivl_on = (ivl_q != '0);
  assign expire = tick_10ms_i && ivl_on && (c10_q == ivl_q - 1'b1);

  always_comb begin
    state_d   = state_q;
    ivl_d     = ivl_q;
    c10_d     = c10_q;
    tc_d      = tc_q;
    start_o   = 1'b0;
    publish_o = 1'b0;
    if (ivl_wr_i) begin
      ivl_d   = ivl_din_i;
      state_d = ST_WAIT;
      c10_d   = '0;
      tc_d    = '0;
    end else if (expire) begin
      start_o   = 1'b1;
      publish_o = (state_q != ST_WAIT);
      state_d   = ST_TRIG;
      c10_d     = '0;
      tc_d      = '0;
    end else begin
      if (tick_10ms_i && ivl_on) c10_d = c10_q + 1'b1;
      if (state_q == ST_TRIG && tick_us_i) begin
        if (tc_q == TC_W'(TRIG_US - 1)) state_d = ST_MEAS;
        else                            tc_d    = tc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      ivl_q   <= '0;
      c10_q   <= '0;
      tc_q    <= '0;
    end else begin
      state_q <= state_d;
      ivl_q   <= ivl_d;
      c10_q   <= c10_d;
      tc_q    <= tc_d;
    end
  end

  assign ivl_o  = ivl_q;
  assign trig_o = (state_q == ST_TRIG);
  assign meas_o = (state_q == ST_MEAS);

  // R4: a zero interval keeps the trigger low
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_q == '0) |-> !trig_o);
  // R5: the trigger only rises on a 10 ms strobe
  p_trig_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(tick_10ms_i));
  // R5: the trigger only falls on a microsecond strobe or an interval write
  p_trig_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_o) |-> $past(tick_us_i || ivl_wr_i));
endmodule

// File: rtl/sonar_echo_chan.sv
module sonar_echo_chan #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             echo_i,
  input  logic             tick_us_i,
  input  logic             meas_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   echo_s;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   seen_q, seen_d;
  logic                   done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], echo_i};
  end
  assign echo_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    done_d = done_q;
    if (clr_i) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      done_d = 1'b0;
    end else if (meas_i && !done_q) begin
      if (echo_s) begin
        seen_d = 1'b1;
        if (tick_us_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else if (seen_q) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      done_q <= done_d;
    end
  end

  assign count_o = cnt_q;

  // R8: a saturated count stays saturated until the next round
  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
  // R7: once the echo has fallen the count is frozen for the round
  p_done_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> $stable(cnt_q));
  // R7: nothing is counted outside the measuring phase
  p_meas_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sonar_bus_regs.sv
module sonar_bus_regs
  import sonar_pkg::*;
#(
  parameter int unsigned CHANNELS = 7,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned IVL_W    = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sel_i,
  input  logic                            regacc_i,
  input  logic                            we_i,
  input  logic [ADDR_DEC_W-1:0]           addr_i,
  input  logic [7:0]                      din_i,
  input  logic [IVL_W-1:0]                ivl_i,
  input  logic                            publish_i,
  input  logic [CHANNELS-1:0][CNT_W-1:0]  counts_i,
  output logic                            ivl_wr_o,
  output logic [7:0]                      dout_o,
  output logic                            ack_o,
  output logic                            stall_o
);
  localparam int unsigned RES_BYTES = CHANNELS * 2;
  localparam int unsigned IVL_ADDR  = RES_BYTES;

  logic [CHANNELS-1:0][CNT_W-1:0] res_q;
  logic                           ready_q, ready_d;
  logic                           rd_last;
  logic [RESULT_W-1:0]            wide;
  logic [7:0]                     rdata;

  assign ivl_wr_o = sel_i && regacc_i && we_i && (addr_i == ADDR_DEC_W'(IVL_ADDR));
  assign rd_last  = sel_i && regacc_i && !we_i && (addr_i == ADDR_DEC_W'(RES_BYTES - 1));

  for (genvar g = 0; g < CHANNELS; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         res_q[g] <= '0;
      else if (publish_i) res_q[g] <= counts_i[g];
    end
  end

  always_comb begin
    ready_d = ready_q;
    if (rd_last)   ready_d = 1'b0;
    if (publish_i) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  always_comb begin
    wide = '0;
    for (int n = 0; n < CHANNELS; n++) begin
      if (addr_i[ADDR_DEC_W-1:1] == (ADDR_DEC_W-1)'(n)) wide = RESULT_W'(res_q[n]);
    end
    rdata = 8'h00;
    if (addr_i < ADDR_DEC_W'(RES_BYTES)) rdata = addr_i[0] ? wide[7:0] : wide[15:8];
    else if (addr_i == ADDR_DEC_W'(IVL_ADDR)) rdata = 8'(ivl_i);
  end

  always_comb begin
    if (!sel_i)        dout_o = din_i;
    else if (regacc_i) dout_o = rdata;
    else               dout_o = ready_q ? 8'(RES_BYTES) : 8'h00;
  end

  assign ack_o   = sel_i && regacc_i;
  assign stall_o = 1'b0;

  // R10: the ready flag only sets when a round publishes
  p_ready_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(publish_i));
  // R11: the ready flag only clears on a read of the last result byte
  p_ready_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> $past(rd_last));
endmodule

// File: rtl/sonar_ring_timer.sv
module sonar_ring_timer
  import sonar_pkg::*;
#(
  parameter int unsigned CHANNELS    = 7,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned IVL_W       = 4,
  parameter int unsigned TRIG_US     = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_regacc,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_din,
  output logic [7:0]          bus_dout,
  output logic                bus_ack,
  output logic                bus_stall,
  input  logic                tick_1us,
  input  logic                tick_10ms,
  output logic                trig_out,
  input  logic [CHANNELS-1:0] echo_in
);
  logic [1:0]                     rst_pipe_q;
  logic                           rst_core_n;
  logic                           ivl_wr;
  logic [IVL_W-1:0]               ivl;
  logic                           meas;
  logic                           start;
  logic                           publish;
  logic [CHANNELS-1:0][CNT_W-1:0] counts;
  logic                           unused_addr_hi;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n     = rst_pipe_q[1];
  assign unused_addr_hi = ^bus_addr[7:ADDR_DEC_W];

  sonar_round_ctl #(.IVL_W(IVL_W), .TRIG_US(TRIG_US)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .ivl_wr_i    (ivl_wr),
    .ivl_din_i   (bus_din[IVL_W-1:0]),
    .tick_us_i   (tick_1us),
    .tick_10ms_i (tick_10ms),
    .ivl_o       (ivl),
    .trig_o      (trig_out),
    .meas_o      (meas),
    .start_o     (start),
    .publish_o   (publish)
  );

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    sonar_echo_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .echo_i    (echo_in[c]),
      .tick_us_i (tick_1us),
      .meas_i    (meas),
      .clr_i     (start),
      .count_o   (counts[c])
    );
  end

  sonar_bus_regs #(.CHANNELS(CHANNELS), .CNT_W(CNT_W), .IVL_W(IVL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sel_i     (bus_sel),
    .regacc_i  (bus_regacc),
    .we_i      (bus_we),
    .addr_i    (bus_addr[ADDR_DEC_W-1:0]),
    .din_i     (bus_din),
    .ivl_i     (ivl),
    .publish_i (publish),
    .counts_i  (counts),
    .ivl_wr_o  (ivl_wr),
    .dout_o    (bus_dout),
    .ack_o     (bus_ack),
    .stall_o   (bus_stall)
  );
endmodule

// File: tb/sonar_ring_timer_test.sv
`timescale 1ns/1ps
module sonar_ring_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 0, rg = 0, we = 0, tus = 0, t10 = 0;
  logic [7:0] addr = 0, din = 0;
  logic [6:0] echo = 0;
  logic [7:0] dout;
  logic       ack, stall, trig;

  int tests = 0, fails = 0;

  // behavioural reference model
  int m_ivl = 0, m_state = 0, m_c10 = 0, m_tc = 0, m_rdy = 0;
  int m_cnt[7], m_hi[7], m_done[7], m_res[7];
  logic [6:0] m_e1 = 0, m_e2 = 0;

  always #2 clk = ~clk;

  sonar_ring_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_regacc(rg), .bus_we(we),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_ack(ack),
    .bus_stall(stall), .tick_1us(tus), .tick_10ms(t10), .trig_out(trig),
    .echo_in(echo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_reg(input int a);
    int v;
    a = a & 15;
    if (a < 14) begin
      v = m_res[a >> 1];
      return (a % 2 == 0) ? (v >> 8) : (v & 255);
    end
    if (a == 14) return m_ivl;
    return 0;
  endfunction

  task automatic model_edge();
    bit hit, wr14, rd13, pub;
    hit  = t10 && m_ivl != 0 && m_c10 == m_ivl - 1;
    wr14 = sel && rg && we && ((addr & 15) == 14);
    rd13 = sel && rg && !we && ((addr & 15) == 13);
    pub  = !wr14 && hit && m_state != 0;
    if (pub) for (int i = 0; i < 7; i++) m_res[i] = m_cnt[i];
    if (rd13) m_rdy = 0;
    if (pub)  m_rdy = 1;
    if (m_state == 2)
      for (int i = 0; i < 7; i++) begin
        if (!m_done[i]) begin
          if (m_e2[i]) begin
            m_hi[i] = 1;
            if (tus && m_cnt[i] < 65535) m_cnt[i]++;
          end else if (m_hi[i]) m_done[i] = 1;
        end
      end
    if (wr14) begin
      m_ivl = din & 15; m_state = 0; m_c10 = 0; m_tc = 0;
    end else if (hit) begin
      m_state = 1; m_c10 = 0; m_tc = 0;
      for (int i = 0; i < 7; i++) begin m_cnt[i] = 0; m_hi[i] = 0; m_done[i] = 0; end
    end else begin
      if (t10 && m_ivl != 0) m_c10++;
      if (m_state == 1 && tus) begin
        if (m_tc == 9) m_state = 2; else m_tc++;
      end
    end
    m_e2 = m_e1;
    m_e1 = echo;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    chk(trig === (m_state == 1), "R6 trigger level per cycle", trig, m_state == 1);
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic tick10();
    t10 = 1; step(); t10 = 0;
  endtask

  task automatic us(input int n);
    tus = 1; repeat (n) step(); tus = 0;
  endtask

  task automatic wr(input int a, input int d);
    sel = 1; rg = 1; we = 1; addr = 8'(a); din = 8'(d);
    step();
    sel = 0; rg = 0; we = 0; addr = 0; din = 0;
  endtask

  task automatic rd(input int a, output int v);
    sel = 1; rg = 1; we = 0; addr = 8'(a);
    #1 v = dout;
    chk(ack === 1'b1, "R2 ack on register access", ack, 1);
    step();
    sel = 0; rg = 0; addr = 0;
  endtask

  task automatic poll(output int v);
    sel = 1; rg = 0; we = 0;
    #1 v = dout;
    sel = 0;
  endtask

  task automatic rd_model(input int a, input string tag);
    int v;
    rd(a, v);
    chk(v == m_reg(a), tag, v, m_reg(a));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    for (int i = 0; i < 7; i++) begin m_cnt[i] = 0; m_hi[i] = 0; m_done[i] = 0; m_res[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);

    // R1 reset state
    chk(trig === 1'b0, "R1 trigger low after reset", trig, 0);
    poll(v); chk(v == 0, "R1 poll after reset", v, 0);
    for (int a = 0; a < 16; a++) begin
      rd(a, v); chk(v == 0, "R1 register after reset", v, 0);
    end

    // R2 pass-through, ignored write, stall
    sel = 0; rg = 1; we = 1; addr = 8'd14; din = 8'hA5;
    #1;
    chk(dout == 8'hA5, "R2 pass-through", dout, 8'hA5);
    chk(ack === 1'b0, "R2 no ack when deselected", ack, 0);
    chk(stall === 1'b0, "R2 stall low", stall, 0);
    step();
    rg = 0; we = 0; addr = 0; din = 0;
    rd(14, v); chk(v == 0, "R2 deselected write ignored", v, 0);

    // R3 aliased address, low nibble of data
    wr(8'h3E, 8'hF3);
    rd(14, v); chk(v == 3, "R3 interval readback", v, 3);
    rd(8'h1E, v); chk(v == 3, "R3 upper address bits ignored", v, 3);

    // R4 interval zero keeps trigger off
    wr(14, 0);
    repeat (3) begin tick10(); idle(1); end
    chk(trig === 1'b0, "R4 no trigger at interval 0", trig, 0);

    // R5 first trigger after N strobes, width of ten us strobes
    wr(14, 2);
    tick10(); idle(2);
    chk(trig === 1'b0, "R5 no trigger before Nth strobe", trig, 0);
    tick10();
    chk(trig === 1'b1, "R5 trigger rises on Nth strobe", trig, 1);
    echo[1] = 1'b1;
    us(9);
    chk(trig === 1'b1, "R5 trigger held through 9 us", trig, 1);
    us(1);
    chk(trig === 1'b0, "R5 trigger falls on 10th us", trig, 0);

    // R7 echo timing, second pulse ignored
    idle(3);
    echo[0] = 1'b1; idle(3);
    us(40);
    echo[1] = 1'b0; idle(3);
    us(60);
    echo[0] = 1'b0; idle(3);
    echo[0] = 1'b1; idle(3);
    us(5);
    echo[0] = 1'b0; idle(3);

    // R10 results not yet visible
    tick10();
    poll(v); chk(v == 0, "R10 no ready before round end", v, 0);
    rd(1, v); chk(v == 0, "R10 result held until round end", v, 0);
    tick10();
    chk(trig === 1'b1, "R6 next trigger at interval end", trig, 1);
    poll(v); chk(v == 8'h0E, "R10 poll returns byte count", v, 8'h0E);
    rd(0, v); chk(v == 8'h00, "R9 ch0 high byte", v, 0);
    rd(1, v); chk(v == 100, "R7 ch0 ignores second pulse", v, 100);
    rd(3, v); chk(v == 40, "R7 ch1 high during trigger counts from trigger end", v, 40);
    rd(7, v); chk(v == 0, "R8 silent channel reports 0", v, 0);
    for (int a = 0; a < 13; a++) rd_model(a, "R9 result bytes");
    poll(v); chk(v == 8'h0E, "R11 other reads keep ready", v, 8'h0E);
    rd_model(13, "R9 last result byte");
    poll(v); chk(v == 0, "R11 read of 13 clears ready", v, 0);

    // R8 saturation
    us(10);
    echo[2] = 1'b1; idle(3);
    us(65600);
    tick10(); tick10();
    rd(4, v); chk(v == 8'hFF, "R8 saturated high byte", v, 8'hFF);
    rd(5, v); chk(v == 8'hFF, "R8 saturated low byte", v, 8'hFF);
    rd(1, v); chk(v == 0, "R8 no echo this round", v, 0);
    for (int a = 0; a < 14; a++) rd_model(a, "R9 result bytes round 2");

    // R12 write mid-round abandons it
    us(10); us(20);
    wr(14, 1);
    chk(trig === 1'b0, "R12 write stops round", trig, 0);
    rd(14, v); chk(v == 1, "R3 new interval", v, 1);
    idle(2);
    poll(v); chk(v == 0, "R12 abandoned round not published", v, 0);
    rd(4, v); chk(v == 8'hFF, "R12 results kept", v, 8'hFF);
    tick10();
    chk(trig === 1'b1, "R12 restart after one strobe", trig, 1);
    poll(v); chk(v == 0, "R12 first trigger publishes nothing", v, 0);
    us(10); us(7);
    tick10();
    poll(v); chk(v == 8'h0E, "R10 ready after restarted round", v, 8'h0E);
    rd(5, v); chk(v == 7, "R12 ch2 counted only new round", v, 7);
    rd(4, v); chk(v == 0, "R9 ch2 high byte", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule